// File: doc/BRIEF.md
# Operand Access-Path Evaluator

This block resolves the operand access path of one instruction per clock. It holds eight address registers and eight data registers, each 32 bits wide. From a request giving the mode, a primary register number, an index register, a displacement field, an operand size and the current program counter, it returns one of two things. For the two register-direct modes it returns the register operand. For every other mode it returns a computed effective address.

For the two auto-modify modes it also reports the updated address register on a write-back port. It commits that new value to its own register file on the same clock edge, so a request in the very next cycle already sees it. Register contents are set through a register-load port.

Each result appears on the outputs one clock after the request. Fetching operands from memory and decoding instructions are left to the surrounding pipeline.

Top module: `ea_eval`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output is zero. All sixteen registers reset to zero.
- R2: Mode 0 (data direct) and mode 1 (address direct) return the selected register's content with `resIsAddr` = 0 and no write-back. Like every result, it appears one cycle after the request.
- R3: Mode 2 (indirect) returns the selected address register's content as the effective address (`resIsAddr` = 1) and leaves the register unchanged.
- R4: Mode 3 (post-increment) returns the old address register value as the address. It also raises `wbValid` for one cycle with `wbReg` = the register number and `wbData` = the old value plus the operand length. Size code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes.
- R5: Mode 4 (pre-decrement) subtracts the operand length from the address register and returns the decremented value both as the address and as `wbData`. Requests in consecutive cycles on the same register each see the previous cycle's update.
- R6: When the primary register number is 7 and the size is byte, the post-increment and pre-decrement step is 2 rather than 1.
- R7: Mode 5 returns the address register plus the 16-bit displacement, sign-extended.
- R8: Mode 6 returns the address register plus the data register numbered by `reqIdxReg`, plus the low 8 bits of `reqDisp` sign-extended.
- R9: Mode 7 returns `reqPc` plus the 16-bit displacement, sign-extended. Mode 8 returns `reqPc` plus the index register plus the low 8 bits of the displacement, sign-extended. In mode 8 the index is an address register when `reqIdxIsAddr` = 1 and a data register otherwise.
- R10: All address sums and register updates wrap modulo 2^32.
- R11: Mode codes 9 to 15, and cycles with `reqValid` low, produce `resValid` = 0, `wbValid` = 0 and all-zero data outputs. `wbValid` is raised only by modes 3 and 4.
- R12: A load (`loadEn`) writes `loadData` into address register `loadReg` when `loadToAddr` = 1, and into data register `loadReg` otherwise. If a load and an auto-modify update target the same address register in one cycle, the loaded value is kept, but the write-back is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqMode | input | 4 | Access-path mode code (0 to 8 used) |
| reqReg | input | 3 | Primary register number |
| reqIdxReg | input | 3 | Index register number |
| reqIdxIsAddr | input | 1 | Mode 8: index taken from the address registers |
| reqDisp | input | 16 | Displacement field; modes 6 and 8 use bits 7:0 |
| reqSize | input | 2 | Operand size code |
| reqPc | input | 32 | Current program counter |
| loadEn | input | 1 | Register-load strobe |
| loadToAddr | input | 1 | Load targets the address registers |
| loadReg | input | 3 | Load register number |
| loadData | input | 32 | Load value |
| resValid | output | 1 | Result valid |
| resIsAddr | output | 1 | Result is an effective address (0: register operand) |
| resValue | output | 32 | Effective address or operand |
| wbValid | output | 1 | Address-register write-back this cycle |
| wbReg | output | 3 | Written address register number |
| wbData | output | 32 | Written value |

## Verification
On every cycle, the assertions check the shape of each result. A write-back only accompanies a valid address result. A post-increment write-back lies exactly 1, 2 or 4 above the reported address, and never 1 for register 7. A pre-decrement write-back equals the reported address. An idle cycle shows zero outputs. The strobes from control never ask for two incompatible actions. Only the bench's scenarios can show the actual arithmetic: sign extension of both displacement widths, index selection, modulo-2^32 wrap, chained pre-decrements that each see the previous update, and a load overriding a simultaneous write-back.

// File: rtl/ea_eval_pkg.sv
`timescale 1ns/1ps
package ea_eval_pkg;

  typedef enum logic [3:0] {
    M_DREG   = 4'd0,
    M_AREG   = 4'd1,
    M_AIND   = 4'd2,
    M_APOST  = 4'd3,
    M_APRE   = 4'd4,
    M_ADISP  = 4'd5,
    M_AIDX   = 4'd6,
    M_PCDISP = 4'd7,
    M_PCIDX  = 4'd8
  } eaMode_e;

  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_WIDE  = 2'd1,
    DISP_SHORT = 2'd2
  } dispSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     valid;
    logic     takeData;
    logic     takeAddr;
    logic     basePc;
    logic     addIndex;
    logic     idxFromAddr;
    dispSel_e dispSel;
    logic     postInc;
    logic     preDec;
  } eaCtrl_t;

endpackage

// File: rtl/ea_eval_ctrl.sv
`timescale 1ns/1ps
module ea_eval_ctrl
  import ea_eval_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [3:0] reqMode,
  input  logic       reqIdxIsAddr,
  output eaCtrl_t    ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.dispSel = DISP_NONE;
    if (reqValid) begin
      case (reqMode)
        M_DREG:   begin ctrl.valid = 1'b1; ctrl.takeData = 1'b1; end
        M_AREG:   begin ctrl.valid = 1'b1; ctrl.takeAddr = 1'b1; end
        M_AIND:   begin ctrl.valid = 1'b1; end
        M_APOST:  begin ctrl.valid = 1'b1; ctrl.postInc = 1'b1; end
        M_APRE:   begin ctrl.valid = 1'b1; ctrl.preDec = 1'b1; end
        M_ADISP:  begin ctrl.valid = 1'b1; ctrl.dispSel = DISP_WIDE; end
        M_AIDX: begin
          ctrl.valid    = 1'b1;
          ctrl.addIndex = 1'b1;
          ctrl.dispSel  = DISP_SHORT;
        end
        M_PCDISP: begin
          ctrl.valid   = 1'b1;
          ctrl.basePc  = 1'b1;
          ctrl.dispSel = DISP_WIDE;
        end
        M_PCIDX: begin
          ctrl.valid       = 1'b1;
          ctrl.basePc      = 1'b1;
          ctrl.addIndex    = 1'b1;
          ctrl.idxFromAddr = reqIdxIsAddr;
          ctrl.dispSel     = DISP_SHORT;
        end
        default: ;
      endcase
    end
  end

  // R11
  side_effect_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.postInc || ctrl.preDec) |-> (ctrl.valid && !ctrl.basePc && !ctrl.addIndex
                                       && !ctrl.takeData && !ctrl.takeAddr));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.takeData, ctrl.takeAddr, ctrl.postInc, ctrl.preDec, ctrl.basePc}));

endmodule

// File: rtl/ea_eval_datapath.sv
`timescale 1ns/1ps
module ea_eval_datapath
  import ea_eval_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int DISP_W   = 16,
  parameter int SHORT_W  = 8,
  localparam int REG_IDX_W = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  eaCtrl_t              ctrl,
  input  logic [REG_IDX_W-1:0] regNum,
  input  logic [REG_IDX_W-1:0] idxNum,
  input  logic [DISP_W-1:0]    disp,
  input  logic [1:0]           size,
  input  logic [DATA_W-1:0]    pc,
  input  logic                 loadEn,
  input  logic                 loadToAddr,
  input  logic [REG_IDX_W-1:0] loadNum,
  input  logic [DATA_W-1:0]    loadData,
  output logic                 resValid,
  output logic                 resIsAddr,
  output logic [DATA_W-1:0]    resValue,
  output logic                 wbValid,
  output logic [REG_IDX_W-1:0] wbReg,
  output logic [DATA_W-1:0]    wbData
);

  localparam int STACK_REG = NUM_REGS - 1;

  logic [DATA_W-1:0] aRegs [NUM_REGS];
  logic [DATA_W-1:0] dRegs [NUM_REGS];

  logic [DATA_W-1:0] aSel, dSel, idxVal, dispVal, baseVal, sumVal;
  logic [DATA_W-1:0] stepVal, newAddr, resultVal;
  logic              autoMod, wbPost;

  always_comb begin
    aSel   = aRegs[regNum];
    dSel   = dRegs[regNum];
    idxVal = ctrl.idxFromAddr ? aRegs[idxNum] : dRegs[idxNum];
    case (ctrl.dispSel)
      DISP_WIDE:  dispVal = {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};
      DISP_SHORT: dispVal = {{(DATA_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
      default:    dispVal = '0;
    endcase
    baseVal = ctrl.basePc ? pc : aSel;
    sumVal  = baseVal + (ctrl.addIndex ? idxVal : '0) + dispVal;
  end

  always_comb begin
    case (size)
      2'd0:    stepVal = (regNum == REG_IDX_W'(STACK_REG)) ? DATA_W'(2) : DATA_W'(1);
      2'd1:    stepVal = DATA_W'(2);
      default: stepVal = DATA_W'(4);
    endcase
    newAddr = ctrl.preDec ? (aSel - stepVal) : (aSel + stepVal);
    autoMod = ctrl.postInc || ctrl.preDec;
    if (ctrl.takeData)      resultVal = dSel;
    else if (ctrl.takeAddr) resultVal = aSel;
    else if (ctrl.preDec)   resultVal = newAddr;
    else                    resultVal = sumVal;
  end

  // Register file: a load overrides an auto-modify update of the same register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        aRegs[i] <= '0;
        dRegs[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (loadEn && loadToAddr && loadNum == REG_IDX_W'(i))
          aRegs[i] <= loadData;
        else if (autoMod && regNum == REG_IDX_W'(i))
          aRegs[i] <= newAddr;
        if (loadEn && !loadToAddr && loadNum == REG_IDX_W'(i))
          dRegs[i] <= loadData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resIsAddr <= 1'b0;
      resValue  <= '0;
      wbValid   <= 1'b0;
      wbReg     <= '0;
      wbData    <= '0;
      wbPost    <= 1'b0;
    end else begin
      resValid  <= ctrl.valid;
      resIsAddr <= ctrl.valid && !ctrl.takeData && !ctrl.takeAddr;
      resValue  <= ctrl.valid ? resultVal : '0;
      wbValid   <= autoMod;
      wbReg     <= autoMod ? regNum : '0;
      wbData    <= autoMod ? newAddr : '0;
      wbPost    <= ctrl.postInc;
    end
  end

  // R11
  wb_needs_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (resValid && resIsAddr));

  // R4
  post_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbPost) |-> ((wbData - resValue) == DATA_W'(1) ||
                             (wbData - resValue) == DATA_W'(2) ||
                             (wbData - resValue) == DATA_W'(4)));

  // R5
  pre_ea_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbPost) |-> (resValue == wbData));

  // R6
  stack_min_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbPost && wbReg == REG_IDX_W'(STACK_REG)) |-> ((wbData - resValue) != DATA_W'(1)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (resValue == '0 && !wbValid && !resIsAddr));

endmodule

// File: rtl/ea_eval.sv
`timescale 1ns/1ps
module ea_eval
  import ea_eval_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int DISP_W   = 16,
  parameter int SHORT_W  = 8,
  localparam int REG_IDX_W = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [3:0]           reqMode,
  input  logic [REG_IDX_W-1:0] reqReg,
  input  logic [REG_IDX_W-1:0] reqIdxReg,
  input  logic                 reqIdxIsAddr,
  input  logic [DISP_W-1:0]    reqDisp,
  input  logic [1:0]           reqSize,
  input  logic [DATA_W-1:0]    reqPc,
  input  logic                 loadEn,
  input  logic                 loadToAddr,
  input  logic [REG_IDX_W-1:0] loadReg,
  input  logic [DATA_W-1:0]    loadData,
  output logic                 resValid,
  output logic                 resIsAddr,
  output logic [DATA_W-1:0]    resValue,
  output logic                 wbValid,
  output logic [REG_IDX_W-1:0] wbReg,
  output logic [DATA_W-1:0]    wbData
);

  eaCtrl_t ctrl;

  ea_eval_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqMode      (reqMode),
    .reqIdxIsAddr (reqIdxIsAddr),
    .ctrl         (ctrl)
  );

  ea_eval_datapath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .DISP_W   (DISP_W),
    .SHORT_W  (SHORT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .regNum     (reqReg),
    .idxNum     (reqIdxReg),
    .disp       (reqDisp),
    .size       (reqSize),
    .pc         (reqPc),
    .loadEn     (loadEn),
    .loadToAddr (loadToAddr),
    .loadNum    (loadReg),
    .loadData   (loadData),
    .resValid   (resValid),
    .resIsAddr  (resIsAddr),
    .resValue   (resValue),
    .wbValid    (wbValid),
    .wbReg      (wbReg),
    .wbData     (wbData)
  );

endmodule

// File: tb/ea_eval_test.sv
`timescale 1ns/1ps
module ea_eval_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqIdxIsAddr, loadEn, loadToAddr;
  logic [3:0]  reqMode;
  logic [2:0]  reqReg, reqIdxReg, loadReg;
  logic [15:0] reqDisp;
  logic [1:0]  reqSize;
  logic [31:0] reqPc, loadData;
  logic        resValid, resIsAddr, wbValid;
  logic [31:0] resValue, wbData;
  logic [2:0]  wbReg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] mA [8];
  logic [31:0] mD [8];

  always #10 clk = ~clk;

  ea_eval uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqReg(reqReg), .reqIdxReg(reqIdxReg), .reqIdxIsAddr(reqIdxIsAddr),
    .reqDisp(reqDisp), .reqSize(reqSize), .reqPc(reqPc),
    .loadEn(loadEn), .loadToAddr(loadToAddr), .loadReg(loadReg), .loadData(loadData),
    .resValid(resValid), .resIsAddr(resIsAddr), .resValue(resValue),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData)
  );

  task automatic compare(input string tag, input bit eV, input bit eA, input logic [31:0] eVal,
                         input bit eW, input logic [2:0] eR, input logic [31:0] eD);
    checks++;
    if (resValid !== eV || resIsAddr !== eA || resValue !== eVal ||
        wbValid !== eW || wbReg !== eR || wbData !== eD) begin
      fails++;
      $display("FAIL %s: got v=%0b a=%0b val=%h wb=%0b r=%0d d=%h, expected v=%0b a=%0b val=%h wb=%0b r=%0d d=%h",
               tag, resValid, resIsAddr, resValue, wbValid, wbReg, wbData,
               eV, eA, eVal, eW, eR, eD);
    end
  endtask

  // One clock: drive at a falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input string tag, input bit v, input int mode, input int r,
                      input int x, input bit xa, input logic [15:0] disp, input int sz,
                      input logic [31:0] pc, input bit ld = 0, input bit ldA = 0,
                      input int ldR = 0, input logic [31:0] ldD = 0);
    logic [31:0] eVal, eD, s16, s8, len, nA;
    bit eV, eA, eW;
    logic [2:0] eR;
    reqValid = v; reqMode = 4'(mode); reqReg = 3'(r); reqIdxReg = 3'(x);
    reqIdxIsAddr = xa; reqDisp = disp; reqSize = 2'(sz); reqPc = pc;
    loadEn = ld; loadToAddr = ldA; loadReg = 3'(ldR); loadData = ldD;
    s16 = {{16{disp[15]}}, disp};
    s8  = {{24{disp[7]}}, disp[7:0]};
    len = (sz == 0) ? ((r == 7) ? 32'd2 : 32'd1) : (sz == 1) ? 32'd2 : 32'd4;
    eV = v && mode <= 8; eA = 0; eVal = 0; eW = 0; eR = 0; eD = 0;
    if (eV) begin
      case (mode)
        0: eVal = mD[r];
        1: eVal = mA[r];
        2: begin eA = 1; eVal = mA[r]; end
        3: begin eA = 1; eVal = mA[r]; eW = 1; eR = 3'(r); eD = mA[r] + len; end
        4: begin nA = mA[r] - len; eA = 1; eVal = nA; eW = 1; eR = 3'(r); eD = nA; end
        5: begin eA = 1; eVal = mA[r] + s16; end
        6: begin eA = 1; eVal = mA[r] + mD[x] + s8; end
        7: begin eA = 1; eVal = pc + s16; end
        default: begin eA = 1; eVal = pc + (xa ? mA[x] : mD[x]) + s8; end
      endcase
    end
    if (eW) mA[r] = eD;
    if (ld) begin
      if (ldA) mA[ldR] = ldD; else mD[ldR] = ldD;
    end
    @(negedge clk);
    compare(tag, eV, eA, eVal, eW, eR, eD);
  endtask

  task automatic idleLoad(input string tag, input bit toA, input int r, input logic [31:0] d);
    step(tag, 0, 0, 0, 0, 0, 16'h0, 0, 32'h0, 1, toA, r, d);
  endtask

  function automatic string tagFor(input bit v, input int mode, input int sz, input int r);
    if (!v || mode > 8) return "R11";
    case (mode)
      0, 1: return "R2";
      2: return "R3";
      3, 4: return (sz == 0 && r == 7) ? "R6" : ((mode == 3) ? "R4" : "R5");
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mA[i] = 0; mD[i] = 0; end
    rstN = 0; reqValid = 0; reqMode = 0; reqReg = 0; reqIdxReg = 0; reqIdxIsAddr = 0;
    reqDisp = 0; reqSize = 0; reqPc = 0; loadEn = 0; loadToAddr = 0; loadReg = 0; loadData = 0;
    repeat (3) @(negedge clk);
    compare("R1", 0, 0, 0, 0, 0, 0);        // outputs during reset
    rstN = 1;
    step("R1", 0, 0, 0, 0, 0, 16'h0, 0, 32'h0);
    for (int i = 0; i < 8; i++) step("R1", 1, 0, i, 0, 0, 16'h0, 2, 32'h0);
    for (int i = 0; i < 8; i++) step("R1", 1, 1, i, 0, 0, 16'h0, 2, 32'h0);

    // R12 loads, outputs stay idle
    for (int i = 0; i < 8; i++) idleLoad("R12", 1, i, 32'h1000 * (i + 1));
    for (int i = 0; i < 8; i++) idleLoad("R12", 0, i, 32'd3 * i + 5);

    step("R2", 1, 0, 4, 0, 0, 16'h0, 0, 32'h0);
    step("R2", 1, 1, 6, 0, 0, 16'h0, 1, 32'h0);
    step("R3", 1, 2, 1, 0, 0, 16'h0, 2, 32'h0);
    step("R3", 1, 1, 1, 0, 0, 16'h0, 2, 32'h0);   // register unchanged

    // R4 / R6: byte post-increment on A2 versus A7
    step("R4", 1, 3, 2, 0, 0, 16'h0, 0, 32'h0);
    step("R6", 1, 3, 7, 0, 0, 16'h0, 0, 32'h0);
    step("R4", 1, 3, 2, 0, 0, 16'h0, 1, 32'h0);
    step("R4", 1, 3, 2, 0, 0, 16'h0, 2, 32'h0);
    step("R4", 1, 3, 2, 0, 0, 16'h0, 3, 32'h0);
    step("R4", 1, 1, 2, 0, 0, 16'h0, 0, 32'h0);

    // R5 back-to-back pre-decrement, then byte on A7 (R6)
    for (int k = 0; k < 3; k++) step("R5", 1, 4, 3, 0, 0, 16'h0, 2, 32'h0);
    step("R5", 1, 4, 3, 0, 0, 16'h0, 0, 32'h0);
    step("R6", 1, 4, 7, 0, 0, 16'h0, 0, 32'h0);
    step("R6", 1, 4, 7, 0, 0, 16'h0, 0, 32'h0);
    step("R5", 1, 1, 3, 0, 0, 16'h0, 0, 32'h0);

    // R7 displacement signs
    step("R7", 1, 5, 1, 0, 0, 16'h7FF0, 0, 32'h0);
    step("R7", 1, 5, 1, 0, 0, 16'h8000, 0, 32'h0);
    // R8 indexed, negative short displacement and upper bits ignored
    step("R8", 1, 6, 0, 5, 1, 16'h1280, 0, 32'h0);
    step("R8", 1, 6, 6, 2, 0, 16'hFF7F, 0, 32'h0);
    // R9 PC relative
    step("R9", 1, 7, 0, 0, 0, 16'hFFFE, 0, 32'h0000_4000);
    step("R9", 1, 8, 0, 4, 1, 16'h0010, 0, 32'h0000_4000);
    step("R9", 1, 8, 0, 4, 0, 16'h00F0, 0, 32'h0000_4000);

    // R10 wrap
    idleLoad("R10", 1, 4, 32'hFFFF_FFFE);
    step("R10", 1, 3, 4, 0, 0, 16'h0, 2, 32'h0);
    step("R10", 1, 1, 4, 0, 0, 16'h0, 2, 32'h0);
    idleLoad("R10", 1, 5, 32'h0);
    step("R10", 1, 4, 5, 0, 0, 16'h0, 0, 32'h0);
    step("R10", 1, 7, 0, 0, 0, 16'h0010, 0, 32'hFFFF_FFF8);

    // R11 unused codes and idle
    step("R11", 1, 9, 2, 0, 0, 16'h1234, 0, 32'h0);
    step("R11", 1, 15, 2, 0, 0, 16'h1234, 0, 32'h0);
    step("R11", 0, 3, 2, 0, 0, 16'h0, 0, 32'h0);
    step("R11", 1, 1, 2, 0, 0, 16'h0, 0, 32'h0);

    // R12 load beats simultaneous post-increment on the same register
    step("R12", 1, 3, 1, 0, 0, 16'h0, 2, 32'h0, 1, 1, 1, 32'hCAFE_0000);
    step("R12", 1, 1, 1, 0, 0, 16'h0, 2, 32'h0);

    for (int i = 0; i < 400; i++) begin
      int mode, r, x, sz;
      bit v, ld;
      mode = $urandom_range(0, 10);
      r = $urandom_range(0, 7);
      x = $urandom_range(0, 7);
      sz = $urandom_range(0, 3);
      v = ($urandom_range(0, 7) != 0);
      ld = ($urandom_range(0, 7) == 0);
      step(tagFor(v, mode, sz, r), v, mode, r, x, 1'($urandom_range(0, 1)),
           16'($urandom), sz, $urandom, ld, 1'($urandom_range(0, 1)),
           $urandom_range(0, 7), $urandom);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule